// File: doc/BRIEF.md
# Masked Input-Port Interrupt Logic

This block serves a four-pin input port that sits behind a small register bus. Each external pin first passes through a synchronizer and then a debouncer driven by a slow sample-enable tick. The filtered levels can be read through a status register. The filtered levels of the three lowest pins also leave the block as dedicated test outputs for the processor.

Every pin has a request flag and a mask bit. A rising edge on a filtered pin latches that pin's flag, but only while its mask bit is set. The OR of all flags forms a port summary flag. The summary flag appears in a separate global request register and drives the interrupt line toward the processor.

One bus read of the request register returns the flags and then clears them, which also clears the summary flag. If a new edge lands in the same cycle as that read, the new edge takes priority over the clear.

Top module: `pin_irq_port`

## Requirements
- R1: After a synchronous active-low reset, all four registers read 0 and `irq_o` and `test_o` are 0. The registers are levels at address 0, flags at address 1, mask at address 2 and global request at address 3.
- R2: A read of address 0 returns the filtered level of pin n in bit n.
- R3: The filtered level takes a new value only on the STABLE_TICKS-th consecutive `tick_i` cycle in which the synchronized pin differs from it (STABLE_TICKS is 4 by default). A tick on which the two agree restarts the count.
- R4: `test_o[n]` equals the filtered level of pin n, for n = 0, 1 and 2.
- R5: A write to address 2 stores the mask, with bit n controlling pin n. A read of address 2 returns the stored mask.
- R6: A rising edge of the filtered level of pin n sets bit n of the flags register at address 1, but only if mask bit n is 1. A falling edge, or a rising edge while the mask bit is 0, leaves the flag unchanged.
- R7: A read of address 1 returns the flags as they stood before the read. It then clears every flag and the summary flag in the following cycle, so `irq_o` falls.
- R8: If an edge would set a flag in the same cycle as a read of address 1, that read returns the value from before the edge, and the flag is set afterwards.
- R9: Bit 0 of address 3 is the OR of all flags, and bits 3 to 1 read 0. `irq_o` is high exactly while that summary bit is 1.
- R10: Writes to addresses 0, 1 and 3 change nothing. Reads of addresses 0, 2 and 3 clear nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 4 | Raw external pin levels |
| tick_i | input | 1 | Slow sample enable for the debouncers |
| bus_addr | input | 2 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data, valid in the cycle of the strobe |
| test_o | output | 3 | Filtered levels of pins 0 to 2 |
| irq_o | output | 1 | Interrupt toward the processor |

## Verification
The bench builds the block with its default parameters: four pins, a two-stage synchronizer and a four-tick debounce window. The short window lets the bench step through the ticks one at a time. It can therefore show that three ticks change nothing and that the fourth one changes the level. It can also interrupt a run with a tick on which the pin agrees with the filtered level and check that the count restarts. Because the tick is driven by hand, the bench can place the cycle in which an edge is detected exactly on a request-register read, which exercises the set-over-clear priority.

// File: rtl/pin_irq_pkg.sv
// Shared definitions for the masked input-port interrupt logic.
// Assumes a two-bit register address space.
package pin_irq_pkg;
    typedef enum logic [1:0] {
        ADDR_LEVEL  = 2'd0,
        ADDR_REQ    = 2'd1,
        ADDR_MASK   = 2'd2,
        ADDR_GLOBAL = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/pin_debounce.sv
// Synchronizes one raw pin and filters it. A new level is accepted only after
// STABLE_TICKS consecutive sample ticks on which the input disagrees with the
// current filtered level. A tick on which the two agree restarts the count.
// Assumes SYNC_STAGES >= 2 and STABLE_TICKS >= 1.
module pin_debounce #(
    parameter int SYNC_STAGES  = 2,
    parameter int STABLE_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic raw_i,
    output logic level_o
);
    localparam int CW = $clog2(STABLE_TICKS + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          cnt_q;
    logic                   level_q;
    logic                   differs;

    assign differs = sync_q[SYNC_STAGES-1] != level_q;

    // Move the raw pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
    end

    // Count disagreeing ticks and accept the new level when the window is full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            level_q <= 1'b0;
        end else if (tick_i) begin
            if (!differs) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(STABLE_TICKS - 1)) begin
                cnt_q   <= '0;
                level_q <= sync_q[SYNC_STAGES-1];
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign level_o = level_q;

    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(level_o)); // R3
    AST_HOLD_WHEN_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !differs) |=> $stable(level_o)); // R3
endmodule

// File: rtl/pin_req_flag.sv
// Rising-edge detector and request flag for one filtered pin. The flag sets on
// a rising edge while the mask is 1 and clears when clr_i is high. In the same
// cycle, a set wins over a clear.
// Assumes level_i is already synchronous to clk.
module pin_req_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    input  logic mask_i,
    input  logic clr_i,
    output logic set_o,
    output logic flag_o
);
    logic level_q;
    logic flag_q;

    assign set_o = level_i & ~level_q & mask_i;

    // Remember the last level and update the flag, with set taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
            flag_q  <= 1'b0;
        end else begin
            level_q <= level_i;
            if (set_o)      flag_q <= 1'b1;
            else if (clr_i) flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;

    AST_SET_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q && !(level_i && !level_q && mask_i)) |=> !flag_o); // R6
    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_o) |=> !flag_o); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && set_o) |=> flag_o); // R8
endmodule

// File: rtl/pin_irq_port.sv
// Four-pin input port with filtered levels, per-pin masked rising-edge request
// flags, a summary flag and an interrupt output, behind a simple register bus.
// A read of the request register clears all flags. Read data is combinational
// in the strobe cycle.
// Assumes NTEST <= NPINS and one-cycle strobes.
module pin_irq_port
    import pin_irq_pkg::*;
#(
    parameter int NPINS        = 4,
    parameter int NTEST        = 3,
    parameter int SYNC_STAGES  = 2,
    parameter int STABLE_TICKS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_i,
    input  logic             tick_i,
    input  logic [1:0]       bus_addr,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [NPINS-1:0] bus_wdata,
    output logic [NPINS-1:0] bus_rdata,
    output logic [NTEST-1:0] test_o,
    output logic             irq_o
);
    logic [NPINS-1:0] level;
    logic [NPINS-1:0] flags;
    logic [NPINS-1:0] sets;
    logic [NPINS-1:0] mask_q;
    logic             rd_req;
    logic             summary;
    reg_addr_e        addr;

    assign addr   = reg_addr_e'(bus_addr);
    assign rd_req = bus_rd && (addr == ADDR_REQ);

    // One filter and one flag per pin.
    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        pin_debounce #(
            .SYNC_STAGES (SYNC_STAGES),
            .STABLE_TICKS(STABLE_TICKS)
        ) u_deb (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_i (tick_i),
            .raw_i  (pin_i[g]),
            .level_o(level[g])
        );
        pin_req_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .level_i(level[g]),
            .mask_i (mask_q[g]),
            .clr_i  (rd_req),
            .set_o  (sets[g]),
            .flag_o (flags[g])
        );
    end

    // Store the mask on writes to its address.
    always_ff @(posedge clk) begin
        if (!rst_n)                             mask_q <= '0;
        else if (bus_wr && addr == ADDR_MASK)   mask_q <= bus_wdata;
    end

    assign summary = |flags;
    assign irq_o   = summary;
    assign test_o  = level[NTEST-1:0];

    // Select read data by address.
    always_comb begin
        unique case (addr)
            ADDR_LEVEL:  bus_rdata = level;
            ADDR_REQ:    bus_rdata = flags;
            ADDR_MASK:   bus_rdata = mask_q;
            ADDR_GLOBAL: bus_rdata = {{(NPINS-1){1'b0}}, summary};
            default:     bus_rdata = '0;
        endcase
    end

    AST_IRQ_DROPS_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && sets == '0) |=> !irq_o); // R7
    AST_MASK_STABLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && addr == ADDR_MASK) |=> $stable(mask_q)); // R10
    AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !rd_req) |=> irq_o); // R9
endmodule

// File: tb/sim_pin_irq_port.sv
// Scoreboard bench: read tasks push expected values, and a monitor compares the
// values when the strobe is sampled.
module sim_pin_irq_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pin_i = '0;
    logic       tick_i = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_wdata = '0;
    logic [3:0] bus_rdata;
    logic [2:0] test_o;
    logic       irq_o;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [3:0] exp_q[$];
    string      tag_q[$];

    pin_irq_port u0 (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .tick_i(tick_i),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .test_o(test_o), .irq_o(irq_o)
    );

    always #4 clk = ~clk;

    task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    // Monitor: compare read data for every strobe seen.
    always @(negedge clk) begin
        #2;
        if (bus_rd) begin
            if (exp_q.size() == 0) check("scoreboard", 4'hx, 4'h0);
            else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    // Driver: one read access, starting and ending at a negedge.
    task automatic do_read(logic [1:0] a, logic [3:0] exp, string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_addr = a;
        bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic do_write(logic [1:0] a, logic [3:0] d);
        bus_addr = a;
        bus_wdata = d;
        bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic tick_pulse();
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick_pulse();
    endtask

    task automatic sync_wait();
        repeat (3) @(negedge clk);
    endtask

    task automatic settle();
        sync_wait();
        ticks(4);
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 20000);
        tests++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 irq", {3'b0, irq_o}, 4'h0);
        check("R1 test", {1'b0, test_o}, 4'h0);
        do_read(2'd0, 4'h0, "R1 level");
        do_read(2'd1, 4'h0, "R1 flags");
        do_read(2'd2, 4'h0, "R1 mask");
        do_read(2'd3, 4'h0, "R1 global");

        // R5 mask write and readback
        do_write(2'd2, 4'b0010);
        do_read(2'd2, 4'b0010, "R5 mask");

        // Pin 0 rises while masked off
        pin_i[0] = 1'b1;
        settle();
        check("R4 test pin0", {1'b0, test_o}, 4'b0001);
        do_read(2'd0, 4'b0001, "R2 level pin0");
        do_read(2'd1, 4'h0, "R6 masked edge");
        check("R6 irq masked", {3'b0, irq_o}, 4'h0);

        // R3 debounce window and restart
        pin_i[1] = 1'b1;
        sync_wait();
        ticks(3);
        check("R3 three ticks", {1'b0, test_o}, 4'b0001);
        pin_i[1] = 1'b0;
        sync_wait();
        ticks(2);
        pin_i[1] = 1'b1;
        sync_wait();
        ticks(3);
        check("R3 restarted", {1'b0, test_o}, 4'b0001);
        tick_pulse();
        check("R3 fourth tick", {1'b0, test_o}, 4'b0011);
        repeat (2) @(negedge clk);

        // R9 summary and irq; R10 no side effects
        check("R9 irq set", {3'b0, irq_o}, 4'h1);
        do_read(2'd3, 4'b0001, "R9 global");
        do_read(2'd3, 4'b0001, "R10 global reread");
        do_write(2'd1, 4'h0);
        do_write(2'd3, 4'h0);
        do_write(2'd0, 4'hF);
        do_read(2'd0, 4'b0011, "R10 level after write");
        do_read(2'd2, 4'b0010, "R10 mask unchanged");
        do_read(2'd1, 4'b0010, "R6 flag pin1");
        // R7 cleared by the previous read
        check("R7 irq low", {3'b0, irq_o}, 4'h0);
        do_read(2'd1, 4'h0, "R7 flags cleared");
        do_read(2'd3, 4'h0, "R7 global cleared");

        // R6 falling edge
        pin_i[1] = 1'b0;
        settle();
        check("R4 test fall", {1'b0, test_o}, 4'b0001);
        do_read(2'd1, 4'h0, "R6 falling edge");

        // R8 set wins over read clear
        do_write(2'd2, 4'b1010);
        pin_i[3] = 1'b1;
        sync_wait();
        ticks(3);
        tick_pulse();
        do_read(2'd1, 4'h0, "R8 read during edge");
        check("R8 irq after", {3'b0, irq_o}, 4'h1);
        do_read(2'd1, 4'b1000, "R8 flag kept");
        do_read(2'd1, 4'h0, "R8 flag cleared");
        do_read(2'd0, 4'b1001, "R2 level pin3");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule